// File: doc/BRIEF.md
# Slot-Aligned Wait-State Generator

This block produces the bus acknowledge for a 68000-style CPU bus running one bus clock per cycle. A free-running phase counter splits time into groups of four cycles. Phases 0 and 1 of each group belong to internal users of the shared RAM, such as video fetch, refresh and sound DMA. The CPU's RAM slot is granted only on a group boundary. An access that starts anywhere else is held with wait states until the next boundary arrives.

Each decoded target region has its own acknowledge rule. The controller also drives the row strobe, the two byte-lane column strobes and the write enable for the CPU's RAM slot. The host decodes the address into six select lines. It drives the address strobe, the read/write line and the two data strobes, and it releases the address strobe after it sees an acknowledge.

Top module: `slot_wait_gen`

## Requirements
- R1: While rst_n is low all six outputs are high. Reset release passes through two synchronising flops. The slot phase is 0 after reset, advances by one on each rising edge from the third edge after rst_n rises, and wraps modulo 4.
- R2: A RAM access (region_sel bit 0) whose address strobe is first sampled low in phase p gets dtack_n low (4-p) mod 4 + 1 cycles later. That is 0, 3, 2 or 1 wait states for p = 0, 1, 2, 3, and dtack_n always falls as the phase becomes 1.
- R3: After a RAM acknowledge, ras_n falls one cycle after dtack_n and the column strobes fall one cycle later still. All strobes return high one cycle after that. Strobes are only ever low in phases 2 and 3.
- R4: Reads and writes get identical timing. we_n goes low together with ras_n only when rw_n is low, and it rises together with ras_n.
- R5: A video-register access (bit 1) gets exactly the RAM wait count but drives no strobes.
- R6: A ROM or cartridge access (bit 2) is acknowledged with zero wait states: dtack_n is low one cycle after the strobe is sampled low.
- R7: A sound-generator access (bit 3) gets one wait state.
- R8: A timer-peripheral access (bit 4) gets four wait states.
- R9: A serial-controller access (bit 5) drives vpa_n low with zero wait states, and dtack_n stays high. dtack_n and vpa_n are never low together.
- R10: dtack_n and vpa_n return high in the cycle after as_n is sampled high.
- R11: While as_n stays low after an acknowledge, the acknowledge is held and no further strobe sequence starts.
- R12: cas_u_n follows uds_n and cas_l_n follows lds_n, as sampled when the column strobe falls.
- R13: An access with no select line high is never acknowledged.
- R14: When several selects are high, the lowest-numbered bit decides the rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one CPU cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| as_n | input | 1 | Address strobe, active low |
| rw_n | input | 1 | High for read, low for write |
| uds_n | input | 1 | Upper data strobe, active low |
| lds_n | input | 1 | Lower data strobe, active low |
| region_sel | input | 6 | Decoded selects: 0 RAM, 1 video regs, 2 ROM, 3 sound, 4 timer, 5 serial |
| dtack_n | output | 1 | Data acknowledge, active low |
| vpa_n | output | 1 | Peripheral-style acknowledge, active low |
| ras_n | output | 1 | RAM row strobe |
| cas_u_n | output | 1 | RAM column strobe, upper byte |
| cas_l_n | output | 1 | RAM column strobe, lower byte |
| we_n | output | 1 | RAM write enable |

## Verification
The assertions check on every cycle that:
- the strobes stay inside the CPU half of the group and the column strobes stay inside the row strobe;
- a RAM acknowledge only appears as the phase becomes 1;
- the two acknowledges never overlap and both drop once the strobe is released;
- ROM and serial accesses answer in one cycle.

The exact wait count for each start phase and each region can only be shown by the directed scenarios, which track the phase from reset on their own. The same holds for the byte-lane and write-enable values, for the held acknowledge without re-arming, and for the silence of an unselected access.

// File: rtl/slot_wait_pkg.sv
package slot_wait_pkg;

  // Number of decoded target selects entering the block.
  localparam int unsigned NUM_SEL = 6;

  // Target region after priority decode; value i+1 corresponds to select bit i.
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_RAM  = 3'd1,
    RG_VID  = 3'd2,
    RG_ROM  = 3'd3,
    RG_SND  = 3'd4,
    RG_TMR  = 3'd5,
    RG_SER  = 3'd6
  } region_e;

  // Acknowledge controller states.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // armed, waiting for an address strobe
    ST_SLOT  = 2'd1,  // waiting for the next group boundary
    ST_COUNT = 2'd2,  // counting fixed wait states
    ST_HOLD  = 2'd3   // acknowledged or ignored, waiting for strobe release
  } ack_state_e;

endpackage

// File: rtl/swg_reset_sync.sv
module swg_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/swg_slot_counter.sv
module swg_slot_counter #(
  parameter  int unsigned SLOT_LEN = 4,
  localparam int unsigned PH_W     = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] ph
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_LEN - 1);

  logic            adv_en;
  logic [PH_W-1:0] ph_d;

  // Free-running: the phase advances on every bus clock.
  assign adv_en = 1'b1;

  always_comb begin
    ph_d = ph;
    if (adv_en) begin
      ph_d = (ph == PH_LAST) ? '0 : ph + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else begin
      ph <= ph_d;
    end
  end

endmodule

// File: rtl/swg_region_decode.sv
module swg_region_decode
  import slot_wait_pkg::*;
(
  input  logic [NUM_SEL-1:0] sel,
  output region_e            region
);

  // Lowest-numbered select wins; scan downward so it is written last.
  always_comb begin
    region = RG_NONE;
    for (int i = NUM_SEL - 1; i >= 0; i--) begin
      if (sel[i]) begin
        region = region_e'(3'(i + 1));
      end
    end
  end

endmodule

// File: rtl/swg_ack_ctrl.sv
module swg_ack_ctrl
  import slot_wait_pkg::*;
#(
  parameter int unsigned PH_W     = 2,
  parameter int unsigned WAIT_W   = 3,
  parameter int unsigned SND_WAIT = 1,
  parameter int unsigned TMR_WAIT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_n,
  input  region_e         region,
  input  logic [PH_W-1:0] ph,
  output logic            dtack_n,
  output logic            vpa_n,
  output logic            grant
);

  localparam logic [WAIT_W-1:0] SND_CNT = WAIT_W'(SND_WAIT);
  localparam logic [WAIT_W-1:0] TMR_CNT = WAIT_W'(TMR_WAIT);

  ack_state_e        st_q,  st_d;
  region_e           reg_q, reg_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              dtack_q, dtack_d;
  logic              vpa_q,   vpa_d;
  logic              at_bound;
  logic [WAIT_W-1:0] fixed_wait;

  assign at_bound   = (ph == '0);
  assign fixed_wait = (region == RG_SND) ? SND_CNT : TMR_CNT;

  always_comb begin
    st_d    = st_q;
    reg_d   = reg_q;
    cnt_d   = cnt_q;
    dtack_d = dtack_q;
    vpa_d   = vpa_q;
    grant   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        dtack_d = 1'b1;
        vpa_d   = 1'b1;
        if (!as_n) begin
          reg_d = region;
          st_d  = ST_HOLD;
          case (region)
            RG_RAM, RG_VID: begin
              if (at_bound) begin
                dtack_d = 1'b0;
                grant   = (region == RG_RAM);
              end else begin
                st_d = ST_SLOT;
              end
            end
            RG_ROM: dtack_d = 1'b0;
            RG_SND, RG_TMR: begin
              if (fixed_wait == '0) begin
                dtack_d = 1'b0;
              end else begin
                cnt_d = fixed_wait - 1'b1;
                st_d  = ST_COUNT;
              end
            end
            RG_SER: vpa_d = 1'b0;
            default: ;
          endcase
        end
      end
      ST_SLOT: begin
        if (as_n) begin
          st_d = ST_IDLE;
        end else if (at_bound) begin
          dtack_d = 1'b0;
          grant   = (reg_q == RG_RAM);
          st_d    = ST_HOLD;
        end
      end
      ST_COUNT: begin
        if (as_n) begin
          st_d = ST_IDLE;
        end else if (cnt_q == '0) begin
          dtack_d = 1'b0;
          st_d    = ST_HOLD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (as_n) begin
          dtack_d = 1'b1;
          vpa_d   = 1'b1;
          st_d    = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      reg_q   <= RG_NONE;
      cnt_q   <= '0;
      dtack_q <= 1'b1;
      vpa_q   <= 1'b1;
    end else begin
      st_q    <= st_d;
      reg_q   <= reg_d;
      cnt_q   <= cnt_d;
      dtack_q <= dtack_d;
      vpa_q   <= vpa_d;
    end
  end

  assign dtack_n = dtack_q;
  assign vpa_n   = vpa_q;

endmodule

// File: rtl/swg_ram_strobe.sv
module swg_ram_strobe #(
  parameter int unsigned SLOT_LEN = 4,
  parameter int unsigned PH_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant,
  input  logic [PH_W-1:0] ph,
  input  logic            rw_n,
  input  logic            uds_n,
  input  logic            lds_n,
  output logic            ras_n,
  output logic            cas_u_n,
  output logic            cas_l_n,
  output logic            we_n
);

  // Grant lands on the boundary edge; row, column and release follow.
  localparam logic [PH_W-1:0] PH_ROW = PH_W'(1);
  localparam logic [PH_W-1:0] PH_COL = PH_W'(2);
  localparam logic [PH_W-1:0] PH_END = PH_W'(SLOT_LEN - 1);

  logic act_q, act_d;
  logic ras_q, ras_d;
  logic cu_q,  cu_d;
  logic cl_q,  cl_d;
  logic we_q,  we_d;

  always_comb begin
    act_d = act_q;
    ras_d = ras_q;
    cu_d  = cu_q;
    cl_d  = cl_q;
    we_d  = we_q;
    if (grant) begin
      act_d = 1'b1;
    end
    if (act_q) begin
      if (ph == PH_ROW) begin
        ras_d = 1'b0;
        we_d  = rw_n;
      end
      if (ph == PH_COL) begin
        cu_d = uds_n;
        cl_d = lds_n;
      end
      if (ph == PH_END) begin
        act_d = 1'b0;
        ras_d = 1'b1;
        cu_d  = 1'b1;
        cl_d  = 1'b1;
        we_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ras_q <= 1'b1;
      cu_q  <= 1'b1;
      cl_q  <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      act_q <= act_d;
      ras_q <= ras_d;
      cu_q  <= cu_d;
      cl_q  <= cl_d;
      we_q  <= we_d;
    end
  end

  assign ras_n   = ras_q;
  assign cas_u_n = cu_q;
  assign cas_l_n = cl_q;
  assign we_n    = we_q;

endmodule

// File: rtl/slot_wait_gen.sv
module slot_wait_gen
  import slot_wait_pkg::*;
#(
  parameter int unsigned SLOT_LEN = 4,
  parameter int unsigned SND_WAIT = 1,
  parameter int unsigned TMR_WAIT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               as_n,
  input  logic               rw_n,
  input  logic               uds_n,
  input  logic               lds_n,
  input  logic [NUM_SEL-1:0] region_sel,
  output logic               dtack_n,
  output logic               vpa_n,
  output logic               ras_n,
  output logic               cas_u_n,
  output logic               cas_l_n,
  output logic               we_n
);

  localparam int unsigned PH_W     = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam int unsigned MAX_WAIT = (SND_WAIT > TMR_WAIT) ? SND_WAIT : TMR_WAIT;
  localparam int unsigned WAIT_W   = (MAX_WAIT > 0) ? $clog2(MAX_WAIT + 1) : 1;

  logic            rst_sync_n;
  logic [PH_W-1:0] ph_q;
  region_e         region;
  logic            grant;

  swg_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  swg_slot_counter #(.SLOT_LEN(SLOT_LEN)) u_slot (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ph    (ph_q)
  );

  swg_region_decode u_dec (
    .sel    (region_sel),
    .region (region)
  );

  swg_ack_ctrl #(
    .PH_W     (PH_W),
    .WAIT_W   (WAIT_W),
    .SND_WAIT (SND_WAIT),
    .TMR_WAIT (TMR_WAIT)
  ) u_ack (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .as_n    (as_n),
    .region  (region),
    .ph      (ph_q),
    .dtack_n (dtack_n),
    .vpa_n   (vpa_n),
    .grant   (grant)
  );

  swg_ram_strobe #(.SLOT_LEN(SLOT_LEN), .PH_W(PH_W)) u_strb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .grant   (grant),
    .ph      (ph_q),
    .rw_n    (rw_n),
    .uds_n   (uds_n),
    .lds_n   (lds_n),
    .ras_n   (ras_n),
    .cas_u_n (cas_u_n),
    .cas_l_n (cas_l_n),
    .we_n    (we_n)
  );

endmodule

// File: rtl/slot_wait_gen_chk.sv
module slot_wait_gen_chk #(
  parameter int unsigned SLOT_LEN = 4,
  parameter int unsigned PH_W     = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            as_n,
  input logic [5:0]      region_sel,
  input logic [PH_W-1:0] ph,
  input logic            dtack_n,
  input logic            vpa_n,
  input logic            ras_n,
  input logic            cas_u_n,
  input logic            cas_l_n
);

  // Strobes only in the CPU half of the group (R3).
  p_strobe_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (ph >= PH_W'(SLOT_LEN / 2)));

  // Column strobes nest inside the row strobe (R3).
  p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_u_n || !cas_l_n) |-> !ras_n);

  // A RAM acknowledge appears only as the phase becomes 1 (R2).
  p_ram_ack_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dtack_n) && (region_sel == 6'b000001)) |-> (ph == PH_W'(1)));

  // Acknowledges drop once the strobe is seen released (R10).
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(as_n) |-> (dtack_n && vpa_n));

  // The two acknowledges never overlap (R9).
  p_ack_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dtack_n && !vpa_n));

  // ROM answers one cycle after a fresh strobe (R6).
  p_rom_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(as_n, 2) && !$past(as_n) && ($past(region_sel) == 6'b000100)) |-> !dtack_n);

  // Serial answers on vpa_n one cycle after a fresh strobe (R9).
  p_ser_vpa_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(as_n, 2) && !$past(as_n) && ($past(region_sel) == 6'b100000)) |-> (!vpa_n && dtack_n));

endmodule

bind slot_wait_gen slot_wait_gen_chk #(.SLOT_LEN(SLOT_LEN), .PH_W(PH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .as_n       (as_n),
  .region_sel (region_sel),
  .ph         (ph_q),
  .dtack_n    (dtack_n),
  .vpa_n      (vpa_n),
  .ras_n      (ras_n),
  .cas_u_n    (cas_u_n),
  .cas_l_n    (cas_l_n)
);

// File: tb/slot_wait_gen_test.sv
module slot_wait_gen_test;

  localparam int CLK_PERIOD = 10;

  typedef enum int {K_RAM, K_VID, K_ROM, K_SND, K_TMR, K_SER, K_NONE} kind_e;

  logic       clk;
  logic       rst_n;
  logic       as_n;
  logic       rw_n;
  logic       uds_n;
  logic       lds_n;
  logic [5:0] region_sel;
  logic       dtack_n, vpa_n, ras_n, cas_u_n, cas_l_n, we_n;

  int n_checks = 0;
  int n_fail   = 0;

  // Bench's own phase model from R1.
  logic [1:0] bph;
  int         rel_edges;

  slot_wait_gen uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .as_n       (as_n),
    .rw_n       (rw_n),
    .uds_n      (uds_n),
    .lds_n      (lds_n),
    .region_sel (region_sel),
    .dtack_n    (dtack_n),
    .vpa_n      (vpa_n),
    .ras_n      (ras_n),
    .cas_u_n    (cas_u_n),
    .cas_l_n    (cas_l_n),
    .we_n       (we_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_edges <= 0;
      bph       <= 2'd0;
    end else if (rel_edges < 2) begin
      rel_edges <= rel_edges + 1;
    end else begin
      bph <= bph + 2'd1;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_bus();
    as_n       = 1'b1;
    rw_n       = 1'b1;
    uds_n      = 1'b1;
    lds_n      = 1'b1;
    region_sel = 6'b0;
  endtask

  // One bus access starting in phase start_ph; checks ack timing, strobes and release.
  task automatic access(input string req, input logic [5:0] sel, input kind_e kind,
                        input int start_ph, input logic rw, input logic u, input logic l,
                        input int extra_hold);
    int         lat;
    logic [1:0] ack_exp;
    logic [2:0] strb_exp;
    logic       we_exp;
    while (bph != 2'(start_ph)) @(negedge clk);
    as_n       = 1'b0;
    region_sel = sel;
    rw_n       = rw;
    uds_n      = u;
    lds_n      = l;
    case (kind)
      K_RAM, K_VID: lat = ((4 - start_ph) % 4) + 1;
      K_ROM, K_SER: lat = 1;
      K_SND:        lat = 2;
      K_TMR:        lat = 5;
      default:      lat = 8;
    endcase
    ack_exp = (kind == K_NONE) ? 2'b11 : (kind == K_SER) ? 2'b10 : 2'b01;
    for (int i = 1; i <= lat; i++) begin
      @(negedge clk);
      if (i < lat) check(req, "ack held off before due cycle", {30'd0, dtack_n, vpa_n}, 32'd3);
      else         check(req, "ack value at due cycle", {30'd0, dtack_n, vpa_n}, {30'd0, ack_exp});
    end
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      if (kind == K_RAM) begin
        strb_exp = (i == 1) ? 3'b011 : (i == 2) ? {1'b0, u, l} : 3'b111;
        we_exp   = (i < 3) ? rw : 1'b1;
      end else begin
        strb_exp = 3'b111;
        we_exp   = 1'b1;
      end
      check(req, "strobes R3 {ras,cas_u,cas_l}", {29'd0, ras_n, cas_u_n, cas_l_n}, {29'd0, strb_exp});
      check(req, "write enable R4", {31'd0, we_n}, {31'd0, we_exp});
    end
    for (int i = 0; i < extra_hold; i++) begin
      @(negedge clk);
      check("R11", "ack held, no new strobes", {29'd0, dtack_n, vpa_n, ras_n},
            {29'd0, ack_exp, 1'b1});
    end
    as_n = 1'b1;
    @(negedge clk);
    check("R10", "ack released after strobe high", {30'd0, dtack_n, vpa_n}, 32'd3);
    idle_bus();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle_bus();
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", {26'd0, dtack_n, vpa_n, ras_n, cas_u_n, cas_l_n, we_n}, 32'h3f);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "outputs after release", {26'd0, dtack_n, vpa_n, ras_n, cas_u_n, cas_l_n, we_n}, 32'h3f);
  endtask

  task automatic t_ram_reads();
    for (int p = 0; p < 4; p++) access("R2", 6'b000001, K_RAM, p, 1'b1, 1'b0, 1'b0, 0);
  endtask

  task automatic t_ram_writes();
    access("R4", 6'b000001, K_RAM, 0, 1'b0, 1'b0, 1'b0, 0);
    access("R4", 6'b000001, K_RAM, 2, 1'b0, 1'b0, 1'b0, 0);
    access("R4", 6'b000001, K_RAM, 3, 1'b0, 1'b0, 1'b1, 0);
  endtask

  task automatic t_lanes();
    access("R12", 6'b000001, K_RAM, 1, 1'b1, 1'b0, 1'b1, 0);
    access("R12", 6'b000001, K_RAM, 2, 1'b0, 1'b1, 1'b0, 0);
  endtask

  task automatic t_video();
    access("R5", 6'b000010, K_VID, 1, 1'b1, 1'b0, 1'b0, 0);
    access("R5", 6'b000010, K_VID, 0, 1'b0, 1'b0, 1'b0, 0);
  endtask

  task automatic t_fixed();
    access("R6", 6'b000100, K_ROM, 2, 1'b1, 1'b0, 1'b0, 0);
    access("R6", 6'b000100, K_ROM, 3, 1'b1, 1'b0, 1'b0, 0);
    access("R7", 6'b001000, K_SND, 0, 1'b0, 1'b0, 1'b0, 0);
    access("R7", 6'b001000, K_SND, 3, 1'b1, 1'b0, 1'b0, 0);
    access("R2", 6'b000001, K_RAM, 1, 1'b1, 1'b0, 1'b0, 0);
    access("R8", 6'b010000, K_TMR, 1, 1'b1, 1'b0, 1'b0, 0);
    access("R9", 6'b100000, K_SER, 2, 1'b1, 1'b0, 1'b0, 0);
  endtask

  task automatic t_misc();
    access("R13", 6'b000000, K_NONE, 0, 1'b1, 1'b0, 1'b0, 0);
    access("R11", 6'b000001, K_RAM, 0, 1'b1, 1'b0, 1'b0, 8);
    access("R14", 6'b000101, K_RAM, 3, 1'b1, 1'b0, 1'b0, 0);
    access("R14", 6'b101100, K_ROM, 1, 1'b1, 1'b0, 1'b0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle_bus();
    @(negedge clk);
    t_reset();
    t_ram_reads();
    t_ram_writes();
    t_lanes();
    t_video();
    t_fixed();
    t_misc();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule